// File: doc/BRIEF.md
# Owner Pointer Cache

This block is a small set-associative store that tells a node which other node currently holds the coherent primary copy of a memory block. A requester looks up a block address. On a hit, the cache returns the owner node number, so that the request can be sent straight to that node. On a miss, the request has to travel to the block's home node instead.

Each entry is one of two kinds. An authoritative entry is kept at the block's home node and names the present owner. A hint entry is kept at any other node and names the node that last invalidated the local copy.

Installs create or overwrite entries. When an install needs space in a full set, the victim is the least recently used hint, and an authoritative entry is displaced only when the set holds no hint. Displacing an authoritative entry raises an eviction notification on a valid/ready output. The surrounding logic uses it to have the owner invalidate every copy and write the block back to memory. Installs are held off while a notification is waiting.

Top module: `owner_ptr_cache`

## Requirements
- R1: A synchronous active-high reset clears every entry. After reset, `ev_valid` is low, `lk_done` is low, `ins_ready` is high, and every lookup misses.
- R2: A lookup presented with `lk_valid` in one cycle produces `lk_done` high in the next cycle, together with `lk_hit` and, on a hit, `lk_owner`. `lk_hit` is never high without `lk_done`.
- R3: An install of an address not yet present stores its owner, and a later lookup of that address hits with that owner.
- R4: An install to an address already present overwrites the owner and the kind in place. This raises no notification, removes no other entry, and makes that way most recently used.
- R5: An invalid way is filled before any valid way is displaced, so the first four distinct addresses of a set all stay resident.
- R6: When a set is full, the least recently used hint entry (`ins_auth` = 0) is evicted, even if an authoritative entry (`ins_auth` = 1) is older.
- R7: When a full set holds only authoritative entries, the least recently used one is evicted. One cycle after the install, `ev_valid` rises with that entry's full address on `ev_addr` and its owner on `ev_owner`.
- R8: Evicting a hint entry raises no notification.
- R9: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_addr` and `ev_owner` hold steady and `ins_ready` is low. An install offered in that time has no effect. `ev_valid` falls one cycle after a cycle with `ev_ready` high.
- R10: A lookup that hits makes that way most recently used, which changes which entry a later install evicts.
- R11: The set index is the low `IDX_W` address bits XOR the next `IDX_W` bits. Addresses with equal index compete for one set, and addresses with different tags never alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup block address |
| lk_done | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup found the address |
| lk_owner | output | NODE_W | Owner node on a hit |
| ins_valid | input | 1 | Install/update request |
| ins_ready | output | 1 | Install accepted this cycle when high |
| ins_addr | input | ADDR_W | Install block address |
| ins_owner | input | NODE_W | Owner node to record |
| ins_auth | input | 1 | 1 = authoritative entry, 0 = hint |
| ev_valid | output | 1 | Authoritative eviction pending |
| ev_ready | input | 1 | Consumer takes the eviction |
| ev_addr | output | ADDR_W | Address of the evicted authoritative entry |
| ev_owner | output | NODE_W | Owner recorded in the evicted entry |

## Verification
The hardest case to reach from the ports is a victim choice that depends on both the entry kind and the recency order at once. One example is a hint evicted while it is the most recently used way and an older authoritative entry sits beside it. Another is an authoritative victim that changes only because an earlier lookup refreshed a different way. The stimulus fills one set with seven addresses that all hash to it, and interleaves hits, in-place kind changes and fresh installs. The order of the set is then known at every step, and each eviction, or its absence, pins down one ranking decision.

// File: rtl/opc_pkg.sv
package opc_pkg;

    typedef enum logic {
        KIND_HINT = 1'b0,
        KIND_AUTH = 1'b1
    } kind_e;

endpackage

// File: rtl/opc_hash.sv
module opc_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    // index folds the two lowest address slices; the tag keeps everything above
    // the low slice, so the low slice can be rebuilt as idx ^ tag[IDX_W-1:0]
    always_comb begin
        idx = addr[IDX_W-1:0] ^ addr[2*IDX_W-1:IDX_W];
        tag = addr[ADDR_W-1:IDX_W];
    end
endmodule

// File: rtl/opc_match.sv
module opc_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 28,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = vld[w] && (tags[w] == tag);
    end

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eq[w] && !hit) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/opc_victim.sv
module opc_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0]            auth,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    output logic [WAY_W-1:0]           way
);
    logic             free_found;
    logic             hint_found;
    logic [AGE_W-1:0] best_age;

    always_comb begin
        way        = '0;
        free_found = 1'b0;
        hint_found = 1'b0;
        best_age   = '0;
        // first choice: an empty way, lowest index
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[w] && !free_found) begin
                free_found = 1'b1;
                way        = WAY_W'(w);
            end
        end
        // second choice: the oldest hint
        if (!free_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!auth[w] && (!hint_found || age[w] > best_age)) begin
                    hint_found = 1'b1;
                    best_age   = age[w];
                    way        = WAY_W'(w);
                end
            end
        end
        // last choice: the oldest way of all
        if (!free_found && !hint_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == AGE_W'(WAYS-1)) begin
                    way = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/opc_age_touch.sv
module opc_age_touch #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic                       en,
    input  logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    // ages form a permutation, 0 = most recent; touching a way ages every
    // younger way by one and makes the touched way the youngest
    always_comb begin
        age_out = age_in;
        if (en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_in[w] < age_in[way]) begin
                    age_out[w] = age_in[w] + AGE_W'(1);
                end
            end
            age_out[way] = '0;
        end
    end
endmodule

// File: rtl/owner_ptr_cache.sv
module owner_ptr_cache #(
    parameter int ADDR_W = 32,
    parameter int NODE_W = 5,
    parameter int IDX_W  = 4,
    parameter int WAYS   = 4,
    localparam int SETS  = 1 << IDX_W,
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [NODE_W-1:0] lk_owner,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [NODE_W-1:0] ins_owner,
    input  logic              ins_auth,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [NODE_W-1:0] ev_owner
);
    import opc_pkg::*;

    typedef struct packed {
        logic              vld;
        kind_e             kind;
        logic [TAG_W-1:0]  tag;
        logic [NODE_W-1:0] own;
    } entry_t;

    typedef struct packed {
        entry_t [SETS-1:0][WAYS-1:0]            ent;
        logic   [SETS-1:0][WAYS-1:0][AGE_W-1:0] age;
        logic                                   ev_vld;
        logic   [ADDR_W-1:0]                    ev_addr;
        logic   [NODE_W-1:0]                    ev_own;
        logic                                   lk_vld;
        logic                                   lk_hit;
        logic   [NODE_W-1:0]                    lk_own;
    } state_t;

    state_t st_d, st_q;

    // address split for both ports
    logic [IDX_W-1:0] lk_idx, ins_idx;
    logic [TAG_W-1:0] lk_tag, ins_tag;

    opc_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_hash (
        .addr(lk_addr), .idx(lk_idx), .tag(lk_tag)
    );
    opc_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ins_hash (
        .addr(ins_addr), .idx(ins_idx), .tag(ins_tag)
    );

    // per-port views of the addressed set
    logic [WAYS-1:0]            lk_vld_v, ins_vld_v, ins_auth_v;
    logic [WAYS-1:0][TAG_W-1:0] lk_tag_v, ins_tag_v;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_vld_v[w]   = st_q.ent[lk_idx][w].vld;
            lk_tag_v[w]   = st_q.ent[lk_idx][w].tag;
            ins_vld_v[w]  = st_q.ent[ins_idx][w].vld;
            ins_tag_v[w]  = st_q.ent[ins_idx][w].tag;
            ins_auth_v[w] = (st_q.ent[ins_idx][w].kind == KIND_AUTH);
        end
    end

    logic             lk_m_hit, ins_m_hit;
    logic [WAY_W-1:0] lk_m_way, ins_m_way, vic_way;

    opc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld(lk_vld_v), .tags(lk_tag_v), .tag(lk_tag),
        .hit(lk_m_hit), .way(lk_m_way)
    );
    opc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ins_match (
        .vld(ins_vld_v), .tags(ins_tag_v), .tag(ins_tag),
        .hit(ins_m_hit), .way(ins_m_way)
    );

    opc_victim #(.WAYS(WAYS)) u_victim (
        .vld(ins_vld_v), .auth(ins_auth_v), .age(st_q.age[ins_idx]),
        .way(vic_way)
    );

    // recency updates: lookup touch first, install touch on top of it
    logic                       lk_touch, ins_fire;
    logic [WAY_W-1:0]           ins_way;
    logic [WAYS-1:0][AGE_W-1:0] lk_age_new, ins_age_base, ins_age_new;

    assign lk_touch = lk_valid && lk_m_hit;
    assign ins_fire = ins_valid && !st_q.ev_vld;
    assign ins_way  = ins_m_hit ? ins_m_way : vic_way;
    assign ins_age_base = (lk_touch && (lk_idx == ins_idx)) ? lk_age_new
                                                            : st_q.age[ins_idx];

    opc_age_touch #(.WAYS(WAYS)) u_lk_touch (
        .age_in(st_q.age[lk_idx]), .en(lk_touch), .way(lk_m_way),
        .age_out(lk_age_new)
    );
    opc_age_touch #(.WAYS(WAYS)) u_ins_touch (
        .age_in(ins_age_base), .en(ins_fire), .way(ins_way),
        .age_out(ins_age_new)
    );

    entry_t vic_ent, new_ent;

    always_comb begin
        vic_ent     = st_q.ent[ins_idx][ins_way];
        new_ent.vld  = 1'b1;
        new_ent.kind = kind_e'(ins_auth);
        new_ent.tag  = ins_tag;
        new_ent.own  = ins_owner;

        st_d = st_q;

        // lookup result register
        st_d.lk_vld = lk_valid;
        st_d.lk_hit = lk_touch;
        st_d.lk_own = lk_touch ? st_q.ent[lk_idx][lk_m_way].own : '0;

        if (lk_touch) begin
            st_d.age[lk_idx] = lk_age_new;
        end

        // eviction handshake
        if (st_q.ev_vld && ev_ready) begin
            st_d.ev_vld = 1'b0;
        end

        // install
        if (ins_fire) begin
            if (!ins_m_hit && vic_ent.vld && (vic_ent.kind == KIND_AUTH)) begin
                st_d.ev_vld  = 1'b1;
                st_d.ev_addr = {vic_ent.tag, vic_ent.tag[IDX_W-1:0] ^ ins_idx};
                st_d.ev_own  = vic_ent.own;
            end
            st_d.ent[ins_idx][ins_way] = new_ent;
            st_d.age[ins_idx]          = ins_age_new;
        end

        if (rst) begin
            st_d = '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_d.age[s][w] = AGE_W'(w);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lk_done   = st_q.lk_vld;
    assign lk_hit    = st_q.lk_hit;
    assign lk_owner  = st_q.lk_own;
    assign ins_ready = !st_q.ev_vld;
    assign ev_valid  = st_q.ev_vld;
    assign ev_addr   = st_q.ev_addr;
    assign ev_owner  = st_q.ev_own;

endmodule

// File: rtl/opc_chk.sv
module opc_chk #(
    parameter int ADDR_W = 32,
    parameter int NODE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_done,
    input logic              lk_hit,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [ADDR_W-1:0] ev_addr,
    input logic [NODE_W-1:0] ev_owner
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !ev_valid && !lk_done && ins_ready);

    // R2
    lookup_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);

    // R2
    lookup_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    // R2
    hit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_done);

    // R9
    ev_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_addr) && $stable(ev_owner));

    // R9
    ev_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev_valid && ev_ready |=> !ev_valid);

    // R7
    ev_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_valid) |-> $past(ins_valid && ins_ready));

endmodule

bind owner_ptr_cache opc_chk #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_done(lk_done),
    .lk_hit(lk_hit), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .ev_owner(ev_owner)
);

// File: tb/owner_ptr_cache_tb.sv
module owner_ptr_cache_tb;
    localparam int ADDR_W = 32;
    localparam int NODE_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_done, lk_hit;
    logic [NODE_W-1:0] lk_owner;
    logic              ins_valid = 1'b0;
    logic              ins_ready;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [NODE_W-1:0] ins_owner = '0;
    logic              ins_auth = 1'b0;
    logic              ev_valid;
    logic              ev_ready = 1'b1;
    logic [ADDR_W-1:0] ev_addr;
    logic [NODE_W-1:0] ev_owner;

    always #10 clk = ~clk;

    owner_ptr_cache u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_owner(lk_owner),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr),
        .ins_owner(ins_owner), .ins_auth(ins_auth),
        .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_addr(ev_addr), .ev_owner(ev_owner)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic              op;      // 0 lookup, 1 install
        logic [31:0]       addr;
        logic [4:0]        own;
        logic              auth;
        logic              exp_hit;
        logic [4:0]        exp_own;
        logic              exp_ev;
        logic [31:0]       exp_ev_addr;
        logic [4:0]        exp_ev_own;
        logic [7:0]        req;
    } vec_t;

    // all addresses below except 0x100 share set 5 (low nibble ^ next nibble)
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h05, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd1},  // R1 empty
        '{1'b1, 32'h05, 5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd3},  // R3
        '{1'b1, 32'h14, 5'd7,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd5},  // R5
        '{1'b1, 32'h27, 5'd9,  1'b1, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd5},  // R5
        '{1'b1, 32'h36, 5'd11, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd5},  // R5 set full
        '{1'b0, 32'h05, 5'd0,  1'b0, 1'b1, 5'd3,  1'b0, 32'h0,  5'd0,  8'd3},  // R3 hit
        '{1'b1, 32'h41, 5'd13, 1'b1, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd8},  // R8 hint out
        '{1'b0, 32'h14, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd6},  // R6
        '{1'b0, 32'h36, 5'd0,  1'b0, 1'b1, 5'd11, 1'b0, 32'h0,  5'd0,  8'd10}, // R10
        '{1'b1, 32'h50, 5'd2,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd6},  // R6 MRU hint out
        '{1'b0, 32'h36, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd6},  // R6
        '{1'b0, 32'h27, 5'd0,  1'b0, 1'b1, 5'd9,  1'b0, 32'h0,  5'd0,  8'd6},  // R6 old auth kept
        '{1'b1, 32'h50, 5'd20, 1'b1, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd4},  // R4 hint->auth
        '{1'b0, 32'h50, 5'd0,  1'b0, 1'b1, 5'd20, 1'b0, 32'h0,  5'd0,  8'd4},  // R4
        '{1'b1, 32'h63, 5'd6,  1'b0, 1'b0, 5'd0,  1'b1, 32'h05, 5'd3,  8'd7},  // R7
        '{1'b0, 32'h05, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd7},  // R7
        '{1'b0, 32'h41, 5'd0,  1'b0, 1'b1, 5'd13, 1'b0, 32'h0,  5'd0,  8'd10}, // R10 refresh
        '{1'b1, 32'h63, 5'd8,  1'b1, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd4},  // R4
        '{1'b1, 32'h05, 5'd1,  1'b1, 1'b0, 5'd0,  1'b1, 32'h27, 5'd9,  8'd10}, // R10
        '{1'b0, 32'h27, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd10}, // R10
        '{1'b0, 32'h63, 5'd0,  1'b0, 1'b1, 5'd8,  1'b0, 32'h0,  5'd0,  8'd4},  // R4
        '{1'b1, 32'h100,5'd17, 1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd11}, // R11 set 0
        '{1'b0, 32'h100,5'd0,  1'b0, 1'b1, 5'd17, 1'b0, 32'h0,  5'd0,  8'd11}, // R11
        '{1'b0, 32'h105,5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 32'h0,  5'd0,  8'd11}  // R11 no alias
    };

    // entered at a falling edge; leaves at a falling edge
    task automatic do_lookup(input logic [31:0] a, input logic eh,
                             input logic [4:0] eo, input string req);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, "lk_done", 32'(lk_done), 32'd1);
        check(req, "lk_hit", 32'(lk_hit), 32'(eh));
        if (eh) check(req, "lk_owner", 32'(lk_owner), 32'(eo));
    endtask

    task automatic do_install(input logic [31:0] a, input logic [4:0] o,
                              input logic au);
        while (!ins_ready) @(negedge clk);
        ins_valid = 1'b1;
        ins_addr  = a;
        ins_owner = o;
        ins_auth  = au;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    logic done = 1'b0;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        string rq;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "ev_valid", 32'(ev_valid), 32'd0);
        check("R1", "lk_done", 32'(lk_done), 32'd0);
        check("R1", "ins_ready", 32'(ins_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d", VECS[i].req);
            if (VECS[i].op == 1'b0) begin
                do_lookup(VECS[i].addr, VECS[i].exp_hit, VECS[i].exp_own, rq);
            end else begin
                do_install(VECS[i].addr, VECS[i].own, VECS[i].auth);
                check(rq, "ev_valid", 32'(ev_valid), 32'(VECS[i].exp_ev));
                if (VECS[i].exp_ev) begin
                    check(rq, "ev_addr", ev_addr, VECS[i].exp_ev_addr);
                    check(rq, "ev_owner", 32'(ev_owner), 32'(VECS[i].exp_ev_own));
                end
            end
        end

        // R9: notification held while the consumer stalls; installs blocked
        while (!ins_ready) @(negedge clk);
        ev_ready = 1'b0;
        do_install(32'h27, 5'd4, 1'b1);
        ins_valid = 1'b1;
        ins_addr  = 32'h200;
        ins_owner = 5'd5;
        ins_auth  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            check("R9", "ev_valid held", 32'(ev_valid), 32'd1);
            check("R9", "ev_addr held", ev_addr, 32'h50);
            check("R9", "ev_owner held", 32'(ev_owner), 32'd20);
            check("R9", "ins_ready low", 32'(ins_ready), 32'd0);
            @(negedge clk);
        end
        ins_valid = 1'b0;
        ev_ready  = 1'b1;
        @(negedge clk);
        check("R9", "ev_valid released", 32'(ev_valid), 32'd0);
        do_lookup(32'h200, 1'b0, 5'd0, "R9");
        do_lookup(32'h27, 1'b1, 5'd4, "R9");

        // R1: reset mid-run wipes the contents
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "ev_valid after reset", 32'(ev_valid), 32'd0);
        check("R1", "lk_done after reset", 32'(lk_done), 32'd0);
        do_lookup(32'h27, 1'b0, 5'd0, "R1");
        do_lookup(32'h100, 1'b0, 5'd0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule